// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a three-state serial analog-to-digital converter and reads one sample per request. A single-cycle `start` pulse opens a frame: chip select goes low, a serial clock derived from the system clock by a fixed divider toggles for 14 or 16 periods, and each returned bit is captured into a shift register. Once the last period is complete, chip select is released together with the final rising edge of the serial clock. The result is then presented with a one-cycle `valid` strobe, and a quiet interval is held before another frame may begin.

The converter emits two leading zeros, then the result MSB first, then zeros up to the end of the frame. The controller removes the leading and trailing zeros and returns only the `RES_W` result bits. Bits are normally captured on serial-clock falling edges, starting with the zero that is present as soon as chip select falls. For slow links, a rising-edge capture option drops that first zero and takes every later bit on the rising edge that follows the edge which launched it. The frame length and the capture edge are both sampled when `start` is accepted and stay fixed until the frame ends.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset `cs_n` and `sclk` are 1, and `busy` and `valid` are 0.
- R2: A `start` pulse seen while `busy` is 0 drives `cs_n` low and `busy` high from the next cycle. `sclk` stays high for the first `DIV_HALF` cycles of the frame.
- R3: `sclk` changes level every `DIV_HALF` system clocks, and a frame has exactly N falling edges. N is 16 when `long_frame` was 1 at start and 14 when it was 0.
- R4: `cs_n` stays low for exactly 2·N·`DIV_HALF` system clocks. It never rises before the N-th falling edge, and it rises on the same cycle as the rising edge that follows that falling edge.
- R5: With `sample_rise` = 0, the frame bit present before falling edge k is captured on that edge. Frame bits 2 to `RES_W`+1, counted from 0 at chip-select fall, appear on `result` with frame bit 2 as the MSB.
- R6: With `sample_rise` = 1, frame bit k is captured on rising edge k, for k from 1 to N−1. `result` holds the same value as in R5.
- R7: Trailing zero bits are discarded, so `result` is the same for N = 14 and N = 16.
- R8: `valid` is a one-cycle pulse on the cycle `cs_n` rises, and `result` holds its value until the next `valid`.
- R9: `busy` stays high for exactly `QUIET_CLKS` cycles after `cs_n` rises, starting with the `valid` cycle, so chip select is high for at least that long between frames.
- R10: `start` is ignored while `busy` is 1, including during the quiet interval. The current frame, its length, its capture edge and its result are unaffected, and no further frame starts afterwards.
- R11: `sclk` is 1 whenever `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one conversion (single-cycle pulse) |
| long_frame | input | 1 | 1: 16-clock frame, 0: 14-clock frame; sampled at start |
| sample_rise | input | 1 | 1: capture on rising edges, 0: on falling edges; sampled at start |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| busy | output | 1 | Frame or quiet interval in progress |
| valid | output | 1 | One-cycle strobe marking a new result |
| result | output | RES_W | Captured conversion result |

## Verification
The assertions assume `sdata` is a single-bit level that changes only after a serial-clock falling edge or a chip-select fall, which is how the converter launches bits. They also assume `start` is a synchronous level that the controller may see in any state. The bench's converter model launches each bit on the falling edge of `sclk` or `cs_n` it observes, so the capturing register always sees the level that existed before the edge. Start pulses are driven between clock edges, at random points inside the frame and inside the quiet interval, together with the opposite frame length and capture edge, to show that these inputs matter only when the controller is idle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2,
    ST_QUIET = 2'd3
  } rd_state_t;

  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned LEAD_ZEROS = 2;
  localparam int unsigned EDGE_W     = 5;

  // Number of serial clock periods in a frame.
  function automatic logic [EDGE_W-1:0] frame_edges(input logic long_sel);
    return long_sel ? EDGE_W'(16) : EDGE_W'(14);
  endfunction

  // Both capture modes leave frame bit i at position n-1-i of the shift
  // register, so the result field starts at n-1-LEAD_ZEROS for either mode.
  function automatic logic [FRAME_BITS-1:0] strip_frame(
      input logic [FRAME_BITS-1:0] word,
      input logic [EDGE_W-1:0]     n,
      input int unsigned           w);
    int unsigned lsb_pos;
    logic [FRAME_BITS-1:0] mask;
    lsb_pos = int'(n) - LEAD_ZEROS - w;
    mask    = (FRAME_BITS'(1) << w) - FRAME_BITS'(1);
    return (word >> lsb_pos) & mask;
  endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int unsigned DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_ev,
  output logic rise_ev
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic tick;

  generate
    if (DIV_HALF <= 1) begin : g_every_cycle
      assign tick = run;
    end else begin : g_divided
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run)
          cnt <= '0;
        else if (cnt == CW'(DIV_HALF - 1))
          cnt <= '0;
        else
          cnt <= cnt + CW'(1);
      end
      assign tick = run && (cnt == CW'(DIV_HALF - 1));
    end
  endgenerate

  assign fall_ev = tick && sclk;
  assign rise_ev = tick && !sclk;

  always_ff @(posedge clk) begin
    if (rst)
      sclk <= 1'b1;
    else if (!run)
      sclk <= 1'b1;
    else if (tick)
      sclk <= ~sclk;
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clear)
      word <= '0;
    else if (shift_en)
      word <= {word[WIDTH-2:0], din};
  end
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned QUIET_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              long_in,
  input  logic              rise_in,
  input  logic              fall_ev,
  input  logic              rise_ev,
  output rd_state_t         state,
  output logic              run,
  output logic              cs_n,
  output logic              busy,
  output logic              accept,
  output logic              cap_en,
  output logic              done,
  output logic              cfg_long,
  output logic              cfg_rise,
  output logic [EDGE_W-1:0] fall_cnt,
  output logic [EDGE_W-1:0] n_edges
);
  localparam int unsigned QW = (QUIET_CLKS > 1) ? $clog2(QUIET_CLKS) : 1;

  logic [QW-1:0] qcnt;
  logic          last_fall;
  logic          quiet_end;

  assign n_edges   = frame_edges(cfg_long);
  assign last_fall = fall_ev && (fall_cnt == n_edges - EDGE_W'(1));
  assign quiet_end = (qcnt == QW'(QUIET_CLKS - 1));

  assign run    = (state == ST_SHIFT) || (state == ST_TAIL);
  assign cs_n   = !run;
  assign busy   = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && start;
  assign done   = (state == ST_TAIL) && rise_ev;
  assign cap_en = (state == ST_SHIFT) && (cfg_rise ? rise_ev : fall_ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cfg_long <= 1'b0;
      cfg_rise <= 1'b0;
      fall_cnt <= '0;
      qcnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cfg_long <= long_in;
            cfg_rise <= rise_in;
            fall_cnt <= '0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (fall_ev) begin
            fall_cnt <= fall_cnt + EDGE_W'(1);
            if (last_fall)
              state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (rise_ev) begin
            qcnt  <= '0;
            state <= ST_QUIET;
          end
        end
        ST_QUIET: begin
          if (quiet_end)
            state <= ST_IDLE;
          else
            qcnt <= qcnt + QW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned DIV_HALF   = 2,
  parameter int unsigned QUIET_CLKS = 4,
  parameter int unsigned RES_W      = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             long_frame,
  input  logic             sample_rise,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             valid,
  output logic [RES_W-1:0] result
);
  generate
    if (RES_W != 8 && RES_W != 10 && RES_W != 12) begin : g_bad_width
      $error("RES_W must be 8, 10 or 12");
    end
    if (QUIET_CLKS < 1) begin : g_bad_quiet
      $error("QUIET_CLKS must be at least 1");
    end
  endgenerate

  rd_state_t              state_w;
  logic                   run_w;
  logic                   fall_ev_w;
  logic                   rise_ev_w;
  logic                   accept_w;
  logic                   cap_en_w;
  logic                   done_w;
  logic                   cfg_long_w;
  logic                   cfg_rise_w;
  logic [EDGE_W-1:0]      fall_cnt_w;
  logic [EDGE_W-1:0]      n_edges_w;
  logic [FRAME_BITS-1:0]  word_w;
  logic [FRAME_BITS-1:0]  stripped_w;

  adc_rd_seq #(.QUIET_CLKS(QUIET_CLKS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .long_in  (long_frame),
    .rise_in  (sample_rise),
    .fall_ev  (fall_ev_w),
    .rise_ev  (rise_ev_w),
    .state    (state_w),
    .run      (run_w),
    .cs_n     (cs_n),
    .busy     (busy),
    .accept   (accept_w),
    .cap_en   (cap_en_w),
    .done     (done_w),
    .cfg_long (cfg_long_w),
    .cfg_rise (cfg_rise_w),
    .fall_cnt (fall_cnt_w),
    .n_edges  (n_edges_w)
  );

  adc_rd_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk     (clk),
    .rst     (rst),
    .run     (run_w),
    .sclk    (sclk),
    .fall_ev (fall_ev_w),
    .rise_ev (rise_ev_w)
  );

  adc_rd_capture #(.WIDTH(FRAME_BITS)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept_w),
    .shift_en (cap_en_w),
    .din      (sdata),
    .word     (word_w)
  );

  assign stripped_w = strip_frame(word_w, n_edges_w, RES_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      result <= '0;
    end else begin
      valid <= done_w;
      if (done_w)
        result <= stripped_w[RES_W-1:0];
    end
  end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       valid,
  input logic       cfg_long,
  input logic       cfg_rise,
  input logic [4:0] fall_cnt,
  input logic [4:0] n_edges
);
  p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (!cs_n && busy && sclk));

  p_cs_rise_full_count_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (fall_cnt == n_edges));

  p_valid_with_cs_r8: assert property (@(posedge clk) disable iff (rst)
    valid |-> $rose(cs_n));

  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_new_frame_after_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !$past(busy));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(cfg_long) && $stable(cfg_rise)));

  p_sclk_idle_high_r11: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .busy     (busy),
  .valid    (valid),
  .cfg_long (cfg_long_w),
  .cfg_rise (cfg_rise_w),
  .fall_cnt (fall_cnt_w),
  .n_edges  (n_edges_w)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;
  localparam int QUIET_CLKS = 4;
  localparam int RES_W      = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic long_frame = 1'b0;
  logic sample_rise = 1'b0;
  logic sdata = 1'b1;
  logic cs_n, sclk, busy, valid;
  logic [RES_W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] model_word = '0;
  int model_idx = 0;
  int model_falls = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_rd_ctrl #(.DIV_HALF(DIV_HALF), .QUIET_CLKS(QUIET_CLKS), .RES_W(RES_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .long_frame(long_frame),
    .sample_rise(sample_rise), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .valid(valid), .result(result)
  );

  // Converter model: first bit at chip-select fall, next bit per sclk fall.
  always @(negedge cs_n) begin
    model_idx = 0;
    model_falls = 0;
    sdata = model_word[15];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      model_falls = model_falls + 1;
      model_idx = model_idx + 1;
      sdata = (model_idx < 16) ? model_word[15 - model_idx] : 1'b0;
    end
  end
  always @(posedge cs_n) sdata = 1'b1;

  function automatic logic [15:0] frame_word(input logic [15:0] d);
    return d << (14 - RES_W);
  endfunction

  function automatic logic [15:0] res_mask(input int w);
    return (16'h1 << w) - 16'h1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input bit lf, input bit rs, input logic [15:0] d,
                           input bit inject);
    int n;
    int cyc;
    int cs_low;
    int first_fall;
    int bcnt;
    bit sclk_bad;
    bit cs_at0;
    bit busy_at0;
    bit extra_valid;
    logic [15:0] exp_res;
    n = lf ? 16 : 14;
    exp_res = d & res_mask(RES_W);
    model_word = frame_word(exp_res);
    @(negedge clk);
    long_frame = lf;
    sample_rise = rs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; cs_low = 0; first_fall = -1; sclk_bad = 1'b0;
    cs_at0 = cs_n; busy_at0 = busy;
    while (!valid && cyc < 2000) begin
      if (!cs_n) cs_low++;
      if (first_fall < 0 && !sclk) first_fall = cyc;
      if (cs_n && !sclk) sclk_bad = 1'b1;
      if (inject && cyc == 5) begin
        start = 1'b1; long_frame = !lf; sample_rise = !rs;
      end
      if (inject && cyc == 6) start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    chk(!cs_at0 && busy_at0, "R2", "cs_n low and busy after start", {30'd0, cs_at0, busy_at0}, 1);
    chk(first_fall == DIV_HALF, "R2", "cycles before first sclk fall", first_fall, DIV_HALF);
    chk(model_falls == n, "R3", "sclk falling edges in frame", model_falls, n);
    chk(cs_low == 2 * n * DIV_HALF, "R4", "cs_n low cycles", cs_low, 2 * n * DIV_HALF);
    if (rs)
      chk(result == exp_res[RES_W-1:0], lf ? "R6" : "R6/R7", "result rising capture", int'(result), int'(exp_res));
    else
      chk(result == exp_res[RES_W-1:0], lf ? "R5" : "R5/R7", "result falling capture", int'(result), int'(exp_res));
    if (inject)
      chk(model_falls == n && result == exp_res[RES_W-1:0], "R10", "start while busy mid-frame", model_falls, n);
    bcnt = 0; extra_valid = 1'b0;
    while (busy && bcnt < 100) begin
      if (bcnt > 0 && valid) extra_valid = 1'b1;
      if (!sclk) sclk_bad = 1'b1;
      if (inject && bcnt == 1) start = 1'b1;
      if (bcnt == 2) start = 1'b0;
      bcnt++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(bcnt == QUIET_CLKS, "R9", "busy cycles after cs_n rise", bcnt, QUIET_CLKS);
    chk(!extra_valid, "R8", "valid single pulse", extra_valid, 0);
    repeat (3) begin
      if (busy || !cs_n || !sclk) sclk_bad = 1'b1;
      @(negedge clk);
    end
    chk(!sclk_bad, "R11", "sclk high and idle while cs_n high", sclk_bad, 0);
    chk(result == exp_res[RES_W-1:0], "R8", "result held after frame", int'(result), int'(exp_res));
    if (inject)
      chk(!busy && cs_n, "R10", "no frame started by ignored starts", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_2468));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && sclk && !busy && !valid, "R1", "reset state",
        {28'd0, cs_n, sclk, busy, valid}, 4'b1100);

    // Directed corners.
    run_frame(1'b1, 1'b0, 16'hFFF, 1'b0);
    run_frame(1'b0, 1'b0, 16'hFFF, 1'b0);
    run_frame(1'b1, 1'b1, 16'hFFF, 1'b0);
    run_frame(1'b0, 1'b1, 16'h000, 1'b0);
    run_frame(1'b1, 1'b0, 16'h800, 1'b0);
    run_frame(1'b0, 1'b1, 16'h001, 1'b0);
    run_frame(1'b1, 1'b1, 16'hA5C, 1'b1);
    run_frame(1'b0, 1'b0, 16'h3C3, 1'b1);

    // Constrained random frames.
    for (int i = 0; i < 16; i++) begin
      logic [15:0] d;
      bit lf, rs, inj;
      d   = 16'($urandom());
      lf  = 1'($urandom());
      rs  = 1'($urandom());
      inj = ($urandom() % 3) == 0;
      run_frame(lf, rs, d, inj);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule